// File: doc/BRIEF.md
# Word Block I/O Transfer Sequencer

This block moves 16-bit words between an I/O port and byte-wide memory, one byte at a time. A command starts it. The command carries a 16-bit memory pointer, an 8-bit word count and an 8-bit port number. It also carries three mode bits: direction, pointer step and single or repeat. Each word takes two byte accesses. The low byte uses the pointer address and the high byte uses the next address. The port number is the same for both bytes. After each word the pointer moves by two, up or down.

In single mode the block moves exactly one word. In repeat mode it decrements the count after every word and stops when the count reaches zero. Memory and port traffic use simple request/ready byte handshakes, and only one access is outstanding at any time. When the command finishes, a one-cycle done pulse marks the end. The current pointer, the current count and a zero indication stay visible on the ports.

Top module: `word_io_seq`

## Requirements
- R1: While idle, `start` high at a clock edge captures `ptr_init`, `cnt_init`, `port_init` and the mode bits, and `busy` rises in the following cycle. The mode bits are `cmd_in` (1 = port to memory, 0 = memory to port), `cmd_dec` (1 = step down, 0 = step up) and `cmd_rep` (1 = repeat, 0 = single).
- R2: Each word moves its low byte at address P and its high byte at address P+1, where P is the pointer at the start of that word. Both bytes use the captured port number. In port-to-memory mode each byte is read from the port (`io_we`=0) and then written to memory (`mem_we`=1). In memory-to-port mode each byte is read from memory and then written to the port. The byte read is the byte written.
- R3: After each word the pointer changes by +2, or by -2 when `cmd_dec`=1, modulo 2^16.
- R4: In single mode exactly one word moves and the count is left unchanged.
- R5: In repeat mode the count drops by one after each word, and words keep moving until it reaches 0. A start count of 0 moves 256 words.
- R6: `done` is high for exactly one cycle when the command completes, and `busy` falls in the next cycle. `zero` is high whenever the count equals 0.
- R7: A memory or port request stays high, with address, port, data and direction unchanged, until its ready is seen. At most one of the two requests is high at a time.
- R8: `start` is ignored while `busy` is high, and this includes the done cycle. The running command finishes with its original settings.
- R9: After reset `busy`, `done`, `mem_req` and `io_req` are low, and the pointer and count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request |
| cmd_in | input | 1 | 1 = port to memory, 0 = memory to port |
| cmd_dec | input | 1 | 1 = pointer steps down |
| cmd_rep | input | 1 | 1 = repeat until count is zero |
| ptr_init | input | 16 | Starting memory pointer |
| cnt_init | input | 8 | Starting word count |
| port_init | input | 8 | Port number |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| zero | output | 1 | Count equals 0 |
| ptr | output | 16 | Current pointer |
| cnt | output | 8 | Current count |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_rdy | input | 1 | Memory access complete |
| io_req | output | 1 | Port byte request |
| io_we | output | 1 | Port write (1) or read (0) |
| io_port | output | 8 | Port number |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data |
| io_rdy | input | 1 | Port access complete |

## Verification
Some properties are checked by assertions on every cycle:
- a request holds stable until it is accepted;
- the two request channels never overlap;
- `done` lasts one cycle;
- each word moves the pointer by exactly two and moves the count by exactly one or by zero;
- the latched settings do not change while `start` is pressed during a busy command.

The bench scenarios cover what a single cycle cannot show:
- the order of byte addresses and the data each byte carries, in all eight mode combinations;
- pointer wrap-around at the ends of the address space;
- the 256-word run that starts from count 0;
- a full command that completes correctly while a stray start is pressed partway through.

// File: rtl/word_io_seq.sv
module word_io_seq #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmd_in,
  input  logic          cmd_dec,
  input  logic          cmd_rep,
  input  logic [AW-1:0] ptr_init,
  input  logic [CW-1:0] cnt_init,
  input  logic [PW-1:0] port_init,
  output logic          busy,
  output logic          done,
  output logic          zero,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] cnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic          io_req,
  output logic          io_we,
  output logic [PW-1:0] io_port,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata,
  input  logic          io_rdy
);

  typedef enum logic [2:0] {S_IDLE, S_BYTE0, S_BYTE1, S_UPD, S_DONE} st_t;

  localparam logic [AW-1:0] STEP_UP = AW'(2);
  localparam logic [AW-1:0] STEP_DN = {{(AW-1){1'b1}}, 1'b0};

  st_t           st;
  logic          stg;
  logic          in_r, dec_r, rep_r;
  logic [PW-1:0] port_r;
  logic [DW-1:0] dat;

  logic          xfer, ack;
  logic [CW-1:0] cnt_dec;

  assign xfer      = (st == S_BYTE0) || (st == S_BYTE1);
  assign mem_req   = xfer && (in_r ? stg : !stg);
  assign io_req    = xfer && (in_r ? !stg : stg);
  assign mem_we    = in_r;
  assign io_we     = !in_r;
  assign mem_addr  = ptr + AW'(st == S_BYTE1);
  assign io_port   = port_r;
  assign mem_wdata = dat;
  assign io_wdata  = dat;
  assign ack       = (mem_req && mem_rdy) || (io_req && io_rdy);
  assign cnt_dec   = cnt - CW'(1);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign zero      = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      stg    <= 1'b0;
      in_r   <= 1'b0;
      dec_r  <= 1'b0;
      rep_r  <= 1'b0;
      port_r <= '0;
      dat    <= '0;
      ptr    <= '0;
      cnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          in_r   <= cmd_in;
          dec_r  <= cmd_dec;
          rep_r  <= cmd_rep;
          ptr    <= ptr_init;
          cnt    <= cnt_init;
          port_r <= port_init;
          stg    <= 1'b0;
          st     <= S_BYTE0;
        end
        S_BYTE0, S_BYTE1: if (ack) begin
          if (!stg) begin
            dat <= in_r ? io_rdata : mem_rdata;
            stg <= 1'b1;
          end else begin
            stg <= 1'b0;
            st  <= (st == S_BYTE0) ? S_BYTE1 : S_UPD;
          end
        end
        S_UPD: begin
          ptr <= ptr + (dec_r ? STEP_DN : STEP_UP);
          if (rep_r) begin
            cnt <= cnt_dec;
            st  <= (cnt_dec != '0) ? S_BYTE0 : S_DONE;
          end else begin
            st  <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && io_req));

  p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_io_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_rdy) |=> (io_req && $stable(io_port) && $stable(io_we) && $stable(io_wdata)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UPD) |=> (ptr == $past(ptr) + ($past(dec_r) ? STEP_DN : STEP_UP)));

  p_cnt_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UPD && rep_r) |=> (cnt == $past(cnt) - CW'(1)));

  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UPD && !rep_r) |=> ($stable(cnt) && done));

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(port_r) && $stable(in_r) && $stable(dec_r) && $stable(rep_r)));

endmodule

// File: tb/word_io_seq_bench.sv
`timescale 1ns/1ps
module word_io_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_in = 1'b0, cmd_dec = 1'b0, cmd_rep = 1'b0;
  logic [15:0] ptr_init = '0;
  logic [7:0]  cnt_init = '0, port_init = '0;
  logic        busy, done, zero;
  logic [15:0] ptr;
  logic [7:0]  cnt;
  logic        mem_req, mem_we, io_req, io_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, io_port, io_wdata;
  logic [7:0]  mem_rdata = '0, io_rdata = '0;
  logic        mem_rdy = 1'b0, io_rdy = 1'b0;

  always #2.5 clk = ~clk;

  word_io_seq u_word_io_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd_in), .cmd_dec(cmd_dec),
    .cmd_rep(cmd_rep), .ptr_init(ptr_init), .cnt_init(cnt_init), .port_init(port_init),
    .busy(busy), .done(done), .zero(zero), .ptr(ptr), .cnt(cnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .io_req(io_req), .io_we(io_we), .io_port(io_port), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rdy(io_rdy));

  int n_chk = 0, n_bad = 0;
  int lat = 0, mwait = 0, iwait = 0;
  int nbytes = 0, io_reads = 0;
  logic        e_in = 1'b0, e_dec = 1'b0;
  logic [15:0] e_p0 = '0;
  logic [7:0]  e_port = '0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] eaddr(input int n);
    logic [15:0] w2 = 16'((n >> 1) * 2);
    return (e_dec ? e_p0 - w2 : e_p0 + w2) + 16'(n & 1);
  endfunction

  // Bus models: ready after `lat` waiting cycles; dest writes are checked against R2.
  always @(negedge clk) begin
    if (mem_rdy) begin
      mem_rdy = 1'b0; mwait = 0;
    end else if (mem_req) begin
      if (mwait >= lat) begin
        mem_rdy = 1'b1;
        if (mem_we) begin
          check(mem_addr == eaddr(nbytes), "R2 mem write addr", mem_addr, eaddr(nbytes));
          check(mem_wdata == 8'(e_port + 8'(nbytes)), "R2 mem write data", mem_wdata, 8'(e_port + 8'(nbytes)));
          check(e_in, "R2 mem write in output mode", 1, 0);
          nbytes++;
        end else begin
          mem_rdata = mem_addr[7:0] ^ 8'h5A;
        end
      end else mwait++;
    end
    if (io_rdy) begin
      io_rdy = 1'b0; iwait = 0;
    end else if (io_req) begin
      if (iwait >= lat) begin
        io_rdy = 1'b1;
        check(io_port == e_port, "R2 port number", io_port, e_port);
        if (io_we) begin
          check(io_wdata == (eaddr(nbytes) & 16'hFF ^ 16'h5A), "R2 port write data", io_wdata, eaddr(nbytes) & 16'hFF ^ 16'h5A);
          check(!e_in, "R2 port write in input mode", 1, 0);
          nbytes++;
        end else begin
          io_rdata = 8'(e_port + 8'(io_reads));
          io_reads++;
        end
      end else iwait++;
    end
  end

  task automatic issue(input logic i, input logic d, input logic r,
                       input logic [15:0] p, input logic [7:0] c, input logic [7:0] pt);
    @(negedge clk);
    e_in = i; e_dec = d; e_p0 = p; e_port = pt; nbytes = 0; io_reads = 0;
    cmd_in = i; cmd_dec = d; cmd_rep = r; ptr_init = p; cnt_init = c; port_init = pt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R1 busy after start", busy, 1);
  endtask

  task automatic finish_and_check(input logic [15:0] xp, input logic [7:0] xc, input int xw, input string tag);
    while (!done) @(negedge clk);
    check(ptr == xp, {tag, " final pointer"}, ptr, xp);
    check(cnt == xc, {tag, " final count"}, cnt, xc);
    check(zero == (xc == 0), "R6 zero flag", zero, xc == 0);
    check(nbytes == 2 * xw, {tag, " bytes moved"}, nbytes, 2 * xw);
    @(negedge clk);
    check(!done && !busy, "R6 done one cycle", {done, busy}, 0);
  endtask

  // {in, dec, rep, ptr, cnt, port, exp_ptr, exp_cnt, exp_words}
  localparam logic [67:0] VEC [9] = '{
    {1'b1, 1'b0, 1'b0, 16'h1000, 8'd5, 8'h20, 16'h1002, 8'd5, 9'd1},
    {1'b1, 1'b1, 1'b0, 16'h2000, 8'd3, 8'h31, 16'h1FFE, 8'd3, 9'd1},
    {1'b0, 1'b0, 1'b0, 16'h00F0, 8'd1, 8'h44, 16'h00F2, 8'd1, 9'd1},
    {1'b0, 1'b1, 1'b0, 16'h0004, 8'd7, 8'h55, 16'h0002, 8'd7, 9'd1},
    {1'b1, 1'b0, 1'b1, 16'h3000, 8'd4, 8'h60, 16'h3008, 8'd0, 9'd4},
    {1'b1, 1'b1, 1'b1, 16'h4010, 8'd3, 8'h71, 16'h400A, 8'd0, 9'd3},
    {1'b0, 1'b0, 1'b1, 16'hFFFC, 8'd3, 8'h82, 16'h0002, 8'd0, 9'd3},
    {1'b0, 1'b1, 1'b1, 16'h0002, 8'd2, 8'h93, 16'hFFFE, 8'd0, 9'd2},
    {1'b1, 1'b0, 1'b1, 16'h0100, 8'd1, 8'hA4, 16'h0102, 8'd0, 9'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !mem_req && !io_req, "R9 reset controls", {busy, done, mem_req, io_req}, 0);
    check(ptr == 0 && cnt == 0, "R9 reset pointer/count", {ptr, cnt}, 0);
    rst_n = 1'b1;

    // R3/R4/R5 table walk across all mode combinations
    for (int k = 0; k < 9; k++) begin
      lat = k % 3;
      issue(VEC[k][67], VEC[k][66], VEC[k][65], VEC[k][64:49], VEC[k][48:41], VEC[k][40:33]);
      finish_and_check(VEC[k][32:17], VEC[k][16:9], int'(VEC[k][8:0]), VEC[k][65] ? "R5 repeat" : "R4 single");
    end

    // R5 start count of 0 wraps to 256 words
    lat = 0;
    issue(1'b1, 1'b0, 1'b1, 16'h5000, 8'd0, 8'h10);
    finish_and_check(16'h5200, 8'd0, 256, "R5 count-zero wrap");

    // R8 start while busy is ignored
    lat = 1;
    issue(1'b1, 1'b0, 1'b1, 16'h6000, 8'd3, 8'h22);
    repeat (4) @(negedge clk);
    cmd_in = 1'b0; cmd_dec = 1'b1; cmd_rep = 1'b0; ptr_init = 16'h9999; cnt_init = 8'd9; port_init = 8'hEE;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1;
    check(ptr == 16'h6006, "R8 pointer unaffected", ptr, 16'h6006);
    check(nbytes == 6, "R8 words unaffected", nbytes, 6);
    @(negedge clk);
    start = 1'b0;
    check(!busy, "R8 start in done cycle ignored", busy, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #750000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule